// File: doc/BRIEF.md
# Host Port Slave with Prefetch Queue

This block lets an external host reach a 32-bit internal address space over a 16-bit parallel port. Two select lines pick one of four host-visible resources: a control word, an address pointer, a data window, and a data window that steps the pointer forward after each word. A half-word select line chooses the low or high 16 bits of any 32-bit quantity. On the inside the block drives a single-beat read/write master port with a request/grant handshake.

Reads can be served from a small prefetch queue. Setting the fetch bit in the control word makes the block read ahead from the pointer into the queue, so the host can take words without waiting on internal traffic. A plain data read discards the queue and always goes to memory. Busy conditions are shown two ways: a `h_ready` output and four not-ready flags in the control word that a host can poll.

A host access is accepted on a rising clock edge where `h_cs` and `h_ready` are both high. The host holds its inputs until then. Read data appears on `h_rdata` from the next cycle and stays there until the next accepted read.

Top module: `host_port_slave`

## Requirements
- R1: `h_sel` selects the resource: 0 control word, 1 address pointer, 2 plain data window, 3 stepping data window. An access completes on an edge where `h_cs` and `h_ready` are both high. For a read, `h_rdata` carries the result from the next cycle on.
- R2: An address write with `h_half`=0 loads pointer bits 15:0, and with `h_half`=1 loads bits 31:16. An address read returns the same halves.
- R3: A data write with `h_half`=0 only latches the low half. A data write with `h_half`=1 posts one memory write of {high, low} to the pointer. Through selector 3 the pointer then grows by 4; through selector 2 it stays unchanged.
- R4: Writing the control word with bit 4 set turns on read-ahead. Memory reads at the pointer and the following words fill the queue up to its depth. Control bit 4 reads 1 while read-ahead is on.
- R5: A selector-3 read of half 0 returns the low half of the oldest queued word, removes that word, and adds 4 to the pointer. The following half-1 read returns the word's high half. If the queue is empty, read-ahead starts by itself and `h_ready` stays low until a word arrives.
- R6: A selector-2 read of half 0 empties the queue, ends read-ahead and reads memory at the pointer. With the port idle and grant delay d, `h_ready` stays low for 3+d cycles. The pointer does not change, and half 1 returns the high half of the word.
- R7: An address write, or a half-1 data write through either data selector, discards all queued words and ends read-ahead. A read-ahead word still in flight at that moment is dropped.
- R8: Control bits 15:12 are read-only not-ready flags. Bit 12 (control) and bit 13 (address) are set while a posted write waits for grant. Bit 14 (plain data) is set while no fetched word waits for a plain read. Bit 15 (stepping data) is set while the queue is empty. Bits 6:5 read 2. Bits 11:7 and 3:0 read 0.
- R9: Control reads are always ready. Control and address writes wait while a posted write is pending. Half-1 data writes wait until the memory port is idle.
- R10: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay stable until `mem_gnt`. Read data is taken in the grant cycle, and only one request is outstanding.
- R11: After reset the pointer is 0, the queue is empty, read-ahead is off, no request is raised, and the control word reads 0xC040.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_cs | input | 1 | Host access strobe, held until accepted |
| h_we | input | 1 | 1 = write, 0 = read |
| h_sel | input | 2 | Resource select |
| h_half | input | 1 | 0 = bits 15:0, 1 = bits 31:16 |
| h_wdata | input | HW | Host write data |
| h_rdata | output | HW | Host read data, registered |
| h_ready | output | 1 | Current access can complete this cycle |
| mem_req | output | 1 | Internal request |
| mem_we | output | 1 | Internal write enable |
| mem_addr | output | 2*HW | Internal byte address |
| mem_wdata | output | 2*HW | Internal write data |
| mem_gnt | input | 1 | Grant; completes the request |
| mem_rdata | input | 2*HW | Read data, valid with grant |

## Verification
The bench builds the block with HW=16 and a queue depth of 2. With that depth, refill after a full queue and wrap of the queue pointers show up within a few words of a stream. The bench memory model sweeps the grant delay over 0 to 3 cycles and then uses a long delay of 20. This exposes the exact stall length of plain reads, the posted-write flags and address-write stalls. The flush tests use addresses whose memory contents differ, so a stale queued word would be visible at the port.

// File: rtl/hps_pkg.sv
// Shared types for the host port slave.
// Assumes a 16-bit or wider host bus; control word fields sit at fixed bits.
package hps_pkg;
    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_ADDR = 2'd1,
        SEL_DATA = 2'd2,
        SEL_DINC = 2'd3
    } hsel_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_PREF  = 2'd1,
        OP_PLAIN = 2'd2,
        OP_WRITE = 2'd3
    } mop_e;

    localparam int FETCH_BIT = 4;
    localparam int NRDY_LSB  = 12;
    localparam logic [1:0] FILL_VAL = 2'b10;
endpackage

// File: rtl/hps_pref_queue.sv
// Prefetch queue: circular buffer of DEPTH words with flush.
// Assumes the caller never pushes when full, never pops when empty,
// and never pops in the same cycle as a flush.
module hps_pref_queue #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST  = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CFULL = CW'(DEPTH);

    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;

    // Storage write; contents need no reset
    always_ff @(posedge clk) begin
        if (push) store[wr_ptr] <= wdata;
    end

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign head  = store[rd_ptr];
    assign empty = (cnt == '0);
    assign full  = (cnt == CFULL);
endmodule

// File: rtl/hps_mem_engine.sv
// Single-outstanding memory master. Takes an operation when idle and
// holds request, address and data stable until grant.
// Assumes start_op is only non-idle in cycles where cur_op is OP_NONE.
module hps_mem_engine
    import hps_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  mop_e          start_op,
    input  logic [DW-1:0] start_addr,
    input  logic [DW-1:0] start_wdata,
    input  logic          mem_gnt,
    output logic          mem_req,
    output logic          mem_we,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output mop_e          cur_op,
    output logic          done
);
    // Operation register: launch from idle, retire on grant
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_op    <= OP_NONE;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else if (cur_op == OP_NONE) begin
            if (start_op != OP_NONE) begin
                cur_op    <= start_op;
                mem_addr  <= start_addr;
                mem_wdata <= start_wdata;
            end
        end else if (mem_gnt) begin
            cur_op <= OP_NONE;
        end
    end

    assign mem_req = (cur_op != OP_NONE);
    assign mem_we  = (cur_op == OP_WRITE);
    assign done    = mem_req && mem_gnt;
endmodule

// File: rtl/host_port_slave.sv
// Host port slave: 16-bit host access to a 32-bit space through control,
// address, data and stepping-data resources, with a read-ahead queue.
// Assumes HW >= 16 and the host holds its inputs until h_ready is seen.
module host_port_slave
    import hps_pkg::*;
#(
    parameter int HW    = 16,
    parameter int DEPTH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            h_cs,
    input  logic            h_we,
    input  logic [1:0]      h_sel,
    input  logic            h_half,
    input  logic [HW-1:0]   h_wdata,
    output logic [HW-1:0]   h_rdata,
    output logic            h_ready,
    output logic            mem_req,
    output logic            mem_we,
    output logic [2*HW-1:0] mem_addr,
    output logic [2*HW-1:0] mem_wdata,
    input  logic            mem_gnt,
    input  logic [2*HW-1:0] mem_rdata
);
    localparam int DW = 2 * HW;
    localparam logic [DW-1:0] STEP = DW'(DW / 8);

    hsel_e         sel;
    mop_e          cur_op, start_op;
    logic          done, eng_idle, wr_pend;
    logic [DW-1:0] addr_q, fa_q, hold_q, start_addr, q_head;
    logic [HW-1:0] wlo_q, ctrl_rd, rd_mux;
    logic          pf_on_q, stale_q, plain_ok_q;
    logic          q_empty, q_full, q_push, q_pop, flush;
    logic          acc, is_data, plain_req, wr_go, fetch_kick;
    logic [3:0]    nrdy;

    assign sel      = hsel_e'(h_sel);
    assign eng_idle = (cur_op == OP_NONE);
    assign wr_pend  = (cur_op == OP_WRITE);
    assign is_data  = (sel == SEL_DATA) || (sel == SEL_DINC);
    assign nrdy     = {q_empty, !plain_ok_q, wr_pend, wr_pend};

    // Readiness of the access currently presented
    always_comb begin
        case (sel)
            SEL_CTRL: h_ready = !h_we || !wr_pend;
            SEL_ADDR: h_ready = !wr_pend;
            SEL_DATA: h_ready = h_we ? (!h_half || eng_idle) : (h_half || plain_ok_q);
            default:  h_ready = h_we ? (!h_half || eng_idle) : (h_half || !q_empty);
        endcase
    end

    assign acc       = h_cs && h_ready;
    assign plain_req = h_cs && (sel == SEL_DATA) && !h_we && !h_half && !plain_ok_q;
    assign wr_go     = acc && h_we && h_half && is_data;
    assign flush     = (acc && h_we && (sel == SEL_ADDR)) || wr_go || plain_req;
    assign fetch_kick = (acc && h_we && (sel == SEL_CTRL) && h_wdata[FETCH_BIT])
                      || (h_cs && !h_we && !h_half && (sel == SEL_DINC) && q_empty);
    assign q_pop     = acc && !h_we && !h_half && (sel == SEL_DINC);
    assign q_push    = done && (cur_op == OP_PREF) && !stale_q && !flush;

    // Launch choice for the memory engine: write, then plain read, then read-ahead
    always_comb begin
        start_op   = OP_NONE;
        start_addr = addr_q;
        if (eng_idle) begin
            if (wr_go) begin
                start_op = OP_WRITE;
            end else if (plain_req) begin
                start_op = OP_PLAIN;
            end else if (pf_on_q && !flush && !q_full) begin
                start_op   = OP_PREF;
                start_addr = fa_q;
            end
        end
    end

    hps_mem_engine #(.DW(DW)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_op   (start_op),
        .start_addr (start_addr),
        .start_wdata({h_wdata, wlo_q}),
        .mem_gnt    (mem_gnt),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .cur_op     (cur_op),
        .done       (done)
    );

    hps_pref_queue #(.W(DW), .DEPTH(DEPTH)) u_q (
        .clk  (clk),
        .rst_n(rst_n),
        .flush(flush),
        .push (q_push),
        .wdata(mem_rdata),
        .pop  (q_pop),
        .head (q_head),
        .empty(q_empty),
        .full (q_full)
    );

    // Address pointer: half-word loads and stepping after selector-3 words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (acc && h_we && (sel == SEL_ADDR)) begin
            if (h_half) addr_q[DW-1:HW] <= h_wdata;
            else        addr_q[HW-1:0]  <= h_wdata;
        end else if (q_pop || (wr_go && (sel == SEL_DINC))) begin
            addr_q <= addr_q + STEP;
        end
    end

    // Read-ahead state: enable flag, next fetch address, drop marker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_on_q <= 1'b0;
            fa_q    <= '0;
            stale_q <= 1'b0;
        end else begin
            if (flush)                    pf_on_q <= 1'b0;
            else if (fetch_kick)          pf_on_q <= 1'b1;
            if (fetch_kick && !pf_on_q && !flush) fa_q <= addr_q;
            else if (q_push)              fa_q <= fa_q + STEP;
            if (done)                     stale_q <= 1'b0;
            else if (flush && (cur_op == OP_PREF)) stale_q <= 1'b1;
        end
    end

    // Plain-read word holder and low-half write latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            plain_ok_q <= 1'b0;
            hold_q     <= '0;
            wlo_q      <= '0;
        end else begin
            if (done && (cur_op == OP_PLAIN)) begin
                plain_ok_q <= 1'b1;
                hold_q     <= mem_rdata;
            end else if (acc && !h_we && !h_half && (sel == SEL_DATA)) begin
                plain_ok_q <= 1'b0;
            end else if (q_pop) begin
                hold_q <= q_head;
            end
            if (acc && h_we && !h_half && is_data) wlo_q <= h_wdata;
        end
    end

    // Control word image
    always_comb begin
        ctrl_rd = '0;
        ctrl_rd[NRDY_LSB +: 4] = nrdy;
        ctrl_rd[6:5]           = FILL_VAL;
        ctrl_rd[FETCH_BIT]     = pf_on_q;
    end

    // Read data select
    always_comb begin
        case (sel)
            SEL_CTRL: rd_mux = ctrl_rd;
            SEL_ADDR: rd_mux = h_half ? addr_q[DW-1:HW] : addr_q[HW-1:0];
            SEL_DATA: rd_mux = h_half ? hold_q[DW-1:HW] : hold_q[HW-1:0];
            default:  rd_mux = h_half ? hold_q[DW-1:HW] : q_head[HW-1:0];
        endcase
    end

    // Host read data register
    always_ff @(posedge clk) begin
        if (!rst_n)             h_rdata <= '0;
        else if (acc && !h_we)  h_rdata <= rd_mux;
    end
endmodule

// File: rtl/host_port_slave_chk.sv
// Port-level protocol checks for host_port_slave, attached by bind.
module host_port_slave_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          h_cs,
    input logic          h_we,
    input logic [1:0]    h_sel,
    input logic          h_half,
    input logic          h_ready,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_gnt,
    input logic [DW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata
);
    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R9
    ctrl_rd_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_cs && (h_sel == 2'd0) && !h_we |-> h_ready);

    // R9
    addr_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_cs && (h_sel == 2'd1) && mem_req && mem_we |-> !h_ready);

    // R3
    wr_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_cs && h_ready && h_we && h_half && h_sel[1] |=> mem_req && mem_we);

    // R3
    wr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) && mem_we |-> $past(h_cs && h_ready && h_we && h_half && h_sel[1]));
endmodule

bind host_port_slave host_port_slave_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .h_cs     (h_cs),
    .h_we     (h_we),
    .h_sel    (h_sel),
    .h_half   (h_half),
    .h_ready  (h_ready),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_gnt  (mem_gnt),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata)
);

// File: tb/sim_host_port_slave.sv
// Bench: memory model with programmable grant delay, host task driver,
// sweeps over grant delays and addresses.
module sim_host_port_slave;
    localparam int HW = 16;
    localparam int DEPTH = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_cs = 1'b0, h_we = 1'b0, h_half = 1'b0;
    logic [1:0]  h_sel = 2'd0;
    logic [15:0] h_wdata = '0;
    logic [15:0] h_rdata;
    logic        h_ready, mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_gnt;

    int errors = 0;
    int checks = 0;
    int gnt_delay = 0;
    int wcnt = 0;
    int nwrites = 0;
    logic [31:0] mem [64];

    always #2 clk = ~clk;

    host_port_slave #(.HW(HW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .h_cs(h_cs), .h_we(h_we), .h_sel(h_sel),
        .h_half(h_half), .h_wdata(h_wdata), .h_rdata(h_rdata), .h_ready(h_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] init_word(input int i);
        return 32'(i + 1) * 32'h9E37_79B9;
    endfunction

    // Memory model with registered grant after gnt_delay waiting cycles
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_gnt   <= 1'b0;
            mem_rdata <= '0;
            wcnt      <= 0;
            for (int i = 0; i < 64; i++) mem[i] <= init_word(i);
        end else if (mem_req && !mem_gnt) begin
            if (wcnt >= gnt_delay) begin
                mem_gnt   <= 1'b1;
                wcnt      <= 0;
                mem_rdata <= mem[mem_addr[7:2]];
                if (mem_we) begin
                    mem[mem_addr[7:2]] <= mem_wdata;
                    nwrites <= nwrites + 1;
                end
            end else begin
                wcnt <= wcnt + 1;
            end
        end else begin
            mem_gnt <= 1'b0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hop(input logic [1:0] s, input logic we, input logic half,
                       input logic [15:0] wd, output logic [15:0] rd, output int stalls);
        @(negedge clk);
        h_cs = 1'b1; h_we = we; h_sel = s; h_half = half; h_wdata = wd;
        stalls = 0;
        #1;
        while (!h_ready && stalls < 2000) begin
            @(negedge clk); #1; stalls++;
        end
        if (stalls >= 2000) chk("R1 hang", 32'(stalls), 32'd0);
        @(posedge clk);
        @(negedge clk);
        rd = h_rdata;
        h_cs = 1'b0; h_we = 1'b0;
    endtask

    task automatic set_addr(input logic [31:0] a);
        logic [15:0] d; int s;
        hop(2'd1, 1'b1, 1'b0, a[15:0], d, s);
        hop(2'd1, 1'b1, 1'b1, a[31:16], d, s);
    endtask

    task automatic get_addr(output logic [31:0] a);
        logic [15:0] lo, hi; int s;
        hop(2'd1, 1'b0, 1'b0, 16'h0, lo, s);
        hop(2'd1, 1'b0, 1'b1, 16'h0, hi, s);
        a = {hi, lo};
    endtask

    task automatic wr32(input logic [1:0] s, input logic [31:0] w);
        logic [15:0] d; int st;
        hop(s, 1'b1, 1'b0, w[15:0], d, st);
        hop(s, 1'b1, 1'b1, w[31:16], d, st);
    endtask

    task automatic rd32(input logic [1:0] s, output logic [31:0] w, output int st0);
        logic [15:0] lo, hi; int st;
        hop(s, 1'b0, 1'b0, 16'h0, lo, st0);
        hop(s, 1'b0, 1'b1, 16'h0, hi, st);
        w = {hi, lo};
    endtask

    task automatic rd_ctrl(output logic [15:0] c);
        int s;
        hop(2'd0, 1'b0, 1'b0, 16'h0, c, s);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] w, a;
        logic [15:0] c;
        int st, wbase;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        chk("R11 mem_req", 32'(mem_req), 32'd0);
        rd_ctrl(c);
        chk("R11 R8 ctrl reset", 32'(c), 32'h0000_C040);
        get_addr(a);
        chk("R11 addr reset", a, 32'd0);

        // R2 address halves
        for (int k = 0; k < 4; k++) begin
            w = 32'h1357_2468 ^ (32'(k) * 32'h0F0F_1111);
            set_addr(w);
            get_addr(a);
            chk("R2 addr readback", a, w);
        end

        // R3 posted writes over grant delays, both selectors; R6 plain reads
        for (int d = 0; d < 4; d++) begin
            gnt_delay = d;
            wbase = 16 * d;
            set_addr(32'(wbase * 4));
            wr32(2'd3, 32'hA000_0000 + 32'(d));
            wr32(2'd3, 32'hB000_0000 + 32'(d));
            get_addr(a);
            chk("R3 stepped addr", a, 32'(wbase * 4 + 8));
            wr32(2'd2, 32'hC000_0000 + 32'(d));
            get_addr(a);
            chk("R3 plain addr held", a, 32'(wbase * 4 + 8));
            rd_ctrl(c);
            chk("R3 word0", mem[wbase], 32'hA000_0000 + 32'(d));
            chk("R3 word1", mem[wbase + 1], 32'hB000_0000 + 32'(d));
            chk("R3 word2", mem[wbase + 2], 32'hC000_0000 + 32'(d));
            for (int k = 0; k < 3; k++) begin
                set_addr(32'((wbase + 4 + k) * 4));
                rd32(2'd2, w, st);
                chk("R6 plain data", w, mem[wbase + 4 + k]);
                chk("R6 plain stall", 32'(st), 32'(3 + d));
                get_addr(a);
                chk("R6 addr unchanged", a, 32'((wbase + 4 + k) * 4));
            end
        end
        chk("R3 write count", 32'(nwrites), 32'd12);

        // R4 R5 streams with read-ahead, queue refill past depth
        for (int d = 0; d < 3; d += 2) begin
            gnt_delay = d;
            set_addr(32'h0000_0020 + 32'(d * 8));
            wr32(2'd0, 32'h0000_0010);
            rd_ctrl(c);
            chk("R4 fetch bit", 32'(c & 16'h0070), 32'h0050);
            for (int n = 0; n < 6; n++) begin
                rd32(2'd3, w, st);
                chk("R5 stream word", w, mem[8 + 2 * d + n]);
            end
            get_addr(a);
            chk("R5 addr stepped", a, 32'h0000_0020 + 32'(d * 8) + 32'd24);
        end

        // R5 read-ahead started by a stepping read on an empty queue
        gnt_delay = 1;
        set_addr(32'h0000_0060);
        rd32(2'd3, w, st);
        chk("R5 auto start", w, mem[24]);
        chk("R5 auto stall", 32'(st > 0), 32'd1);
        rd_ctrl(c);
        chk("R5 R4 bit on", 32'(c[4]), 32'd1);

        // R7 data write discards queued words
        gnt_delay = 0;
        set_addr(32'h0000_0080);
        wr32(2'd0, 32'h0000_0010);
        repeat (20) @(negedge clk);
        wr32(2'd2, 32'h5EED_0F0F);
        rd32(2'd3, w, st);
        chk("R7 write flush", w, 32'h5EED_0F0F);
        rd32(2'd3, w, st);
        chk("R7 next after flush", w, mem[33]);

        // R7 address write discards queued words
        set_addr(32'h0000_0090);
        wr32(2'd0, 32'h0000_0010);
        repeat (20) @(negedge clk);
        set_addr(32'h0000_00A0);
        rd_ctrl(c);
        chk("R7 fetch off", 32'(c[4]), 32'd0);
        rd32(2'd3, w, st);
        chk("R7 addr flush", w, mem[40]);

        // R7 in-flight read-ahead dropped under long grant delay
        gnt_delay = 6;
        set_addr(32'h0000_00B0);
        wr32(2'd0, 32'h0000_0010);
        set_addr(32'h0000_00C0);
        rd32(2'd3, w, st);
        chk("R7 inflight drop", w, mem[48]);

        // R6 plain read ends read-ahead
        gnt_delay = 0;
        set_addr(32'h0000_00D0);
        wr32(2'd0, 32'h0000_0010);
        repeat (10) @(negedge clk);
        rd32(2'd2, w, st);
        chk("R6 plain after fetch", w, mem[52]);
        rd_ctrl(c);
        chk("R6 R8 ctrl after plain", 32'(c), 32'h0000_C040);

        // R8 R9 flags and stalls with a pending posted write
        gnt_delay = 20;
        set_addr(32'h0000_00E0);
        wr32(2'd2, 32'h0BAD_CAFE);
        rd_ctrl(c);
        chk("R8 flags write pending", 32'(c), 32'h0000_F040);
        hop(2'd1, 1'b1, 1'b0, 16'h00E4, c, st);
        chk("R9 addr write stalled", 32'(st > 0), 32'd1);
        rd_ctrl(c);
        chk("R8 flags after write", 32'(c), 32'h0000_C040);
        chk("R3 delayed write", mem[56], 32'h0BAD_CAFE);
        get_addr(a);
        chk("R1 R2 low half only", a, 32'h0000_00E4);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule